// File: doc/BRIEF.md
# Coefficient Pair Byte Packer

This block turns one polynomial of 256 twelve-bit coefficients, held in a RAM with a single registered read port, into a stream of 384 bytes. Coefficients are taken two at a time. Each pair becomes three bytes, so the output has no padding between neighbouring values.

A start pulse carries a polynomial index and a split point `kPolys`. Indices below the split read the result region of the RAM. Indices at or above the split read the secret region. The RAM has only one read port, so the two reads for a pair are issued one after the other. They are scheduled inside the three cycles that the pair's bytes spend on the output. As a result, the stream runs at one byte per cycle whenever the consumer is ready.

The byte stream uses a valid/ready handshake. It marks its final byte with a last flag, and a done pulse follows that byte.

Top module: `coef_pair_packer`

## Requirements
- R1: For pair p, coefficient c0 is read at in-polynomial index 2p and c1 at index 2p+1, with p running 0 to 127. The RAM address is {relative polynomial index, coefficient index[7:0]}, and read data appears one cycle after a cycle with `ramRen` high. Each run issues exactly 256 reads.
- R2: The first byte of each pair equals c0[7:0].
- R3: The second byte of each pair equals {c1[3:0], c0[11:8]}.
- R4: The third byte of each pair equals c1[11:4].
- R5: If the polynomial index is below `kPolys`, reads go to the result region (`ramSel`=0) at relative index equal to the polynomial index. Otherwise they go to the secret region (`ramSel`=1) at relative index (polynomial index − `kPolys`).
- R6: A run delivers exactly 384 bytes. `outLast` is high with the 384th byte only.
- R7: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` holds its value. No coefficient is lost across a stall.
- R8: `done` is high for exactly one cycle, in the cycle after the last byte is accepted. From that cycle on, `outValid` is low.
- R9: A start pulse that arrives during a run has no effect on that run's bytes.
- R10: With `outReady` held high, consecutive bytes of a run are accepted on consecutive cycles, so the 384 bytes span 384 cycles.
- R11: After reset, `outValid`, `done` and `ramRen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| polyIdx | input | POLY_W | Polynomial index for the run |
| kPolys | input | POLY_W | Split point between result and secret regions |
| ramRen | output | 1 | RAM read enable |
| ramSel | output | 1 | Region select: 0 result, 1 secret |
| ramAddr | output | REL_W+8 | {relative polynomial, coefficient index} |
| ramRdata | input | 12 | Registered read data, one cycle after `ramRen` |
| outData | output | 8 | Output byte |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Consumer ready |
| outLast | output | 1 | Marks the final byte of the polynomial |
| done | output | 1 | One-cycle pulse after the final byte is accepted |

## Verification
A faulty read schedule (a skipped or doubled read, or a mistimed capture) shows up as a wrong nibble in the second or third byte of a pair. That byte appears within three output bytes of the fault. A faulty pair counter or region decode makes the first byte of the run, or of the next pair, differ from the expected value. A faulty stall path shows up on the cycle after the first low `outReady`, either as a changed byte or a dropped valid. A faulty end-of-run state shows up at byte 384 or one cycle after it, as a misplaced last flag, a missing done pulse or an extra byte.

// File: rtl/coef_pair_packer_pkg.sv
package coef_pair_packer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PRIME0 = 3'd1,
    ST_PRIME1 = 3'd2,
    ST_OB0    = 3'd3,
    ST_OB1    = 3'd4,
    ST_OB2    = 3'd5
  } packState_e;

  typedef enum logic [1:0] {
    BYTE_LO  = 2'd0,
    BYTE_MID = 2'd1,
    BYTE_HI  = 2'd2
  } byteSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     latchPoly;
    logic     issueRd;
    logic     rdOdd;
    logic     loadByte;
    byteSel_e byteSel;
  } packStrobe_t;

endpackage

// File: rtl/coef_pair_packer_ctrl.sv
module coef_pair_packer_ctrl
  import coef_pair_packer_pkg::*;
#(
  parameter int PAIR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              outReady,
  output packStrobe_t       strobe,
  output logic [PAIR_W-1:0] rdPair,
  output logic              outValid,
  output logic              outLast,
  output logic              done
);

  localparam logic [PAIR_W-1:0] LAST_PAIR = {PAIR_W{1'b1}};

  packState_e        state, stateNext;
  logic [PAIR_W-1:0] pairIdx;
  logic              issued;
  logic              fire;
  logic              lastPair;

  assign lastPair = (pairIdx == LAST_PAIR);
  assign outValid = (state == ST_OB0) || (state == ST_OB1) || (state == ST_OB2);
  assign outLast  = (state == ST_OB2) && lastPair;
  assign fire     = outValid && outReady;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    rdPair    = pairIdx + PAIR_W'(1);
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.latchPoly = 1'b1;
          stateNext        = ST_PRIME0;
        end
      end
      ST_PRIME0: begin
        rdPair         = pairIdx;
        strobe.issueRd = 1'b1;
        stateNext      = ST_PRIME1;
      end
      ST_PRIME1: begin
        rdPair          = pairIdx;
        strobe.issueRd  = 1'b1;
        strobe.rdOdd    = 1'b1;
        strobe.loadByte = 1'b1;
        strobe.byteSel  = BYTE_LO;
        stateNext       = ST_OB0;
      end
      ST_OB0: begin
        if (fire) begin
          strobe.loadByte = 1'b1;
          strobe.byteSel  = BYTE_MID;
          stateNext       = ST_OB1;
        end
      end
      ST_OB1: begin
        // fetch c0 of the next pair while byte 1 is on the output
        if (!issued && !lastPair) strobe.issueRd = 1'b1;
        if (fire) begin
          strobe.loadByte = 1'b1;
          strobe.byteSel  = BYTE_HI;
          stateNext       = ST_OB2;
        end
      end
      ST_OB2: begin
        // fetch c1 of the next pair while byte 2 is on the output
        if (!issued && !lastPair) begin
          strobe.issueRd = 1'b1;
          strobe.rdOdd   = 1'b1;
        end
        if (fire) begin
          if (lastPair) begin
            stateNext = ST_IDLE;
          end else begin
            strobe.loadByte = 1'b1;
            strobe.byteSel  = BYTE_LO;
            stateNext       = ST_OB0;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pairIdx <= '0;
      issued  <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_OB2) && fire && lastPair;
      if (stateNext != state) issued <= 1'b0;
      else if (strobe.issueRd) issued <= 1'b1;
      if (strobe.latchPoly) pairIdx <= '0;
      else if ((state == ST_OB2) && fire && !lastPair) pairIdx <= pairIdx + PAIR_W'(1);
    end
  end

  // no read is issued while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !strobe.issueRd);

  // a start pulse during a run leaves the pair counter alone
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && outValid && !fire) |=> $stable(pairIdx));

endmodule

// File: rtl/coef_pair_packer_dp.sv
module coef_pair_packer_dp
  import coef_pair_packer_pkg::*;
#(
  parameter int POLY_W  = 5,
  parameter int REL_W   = 4,
  parameter int COEF_W  = 12,
  parameter int N_COEFF = 256
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  packStrobe_t                  strobe,
  input  logic [$clog2(N_COEFF)-2:0]   rdPair,
  input  logic [POLY_W-1:0]            polyIdx,
  input  logic [POLY_W-1:0]            kPolys,
  output logic                         ramRen,
  output logic                         ramSel,
  output logic [REL_W+$clog2(N_COEFF)-1:0] ramAddr,
  input  logic [COEF_W-1:0]            ramRdata,
  output logic [7:0]                   outData
);

  localparam int IDX_W = $clog2(N_COEFF);

  logic              regionSel;
  logic [REL_W-1:0]  relIdx;
  logic              capPending;
  logic              capOdd;
  logic [COEF_W-1:0] c0Reg, c1Reg;
  logic [COEF_W-1:0] c0Now, c1Now;
  logic              isSecret;
  logic [POLY_W-1:0] relFull;

  // region decode at start
  assign isSecret = (polyIdx >= kPolys);
  assign relFull  = isSecret ? (polyIdx - kPolys) : polyIdx;

  assign ramRen  = strobe.issueRd;
  assign ramSel  = regionSel;
  assign ramAddr = {relIdx, rdPair, strobe.rdOdd};

  // read data landing this cycle bypasses the holding register
  assign c0Now = (capPending && !capOdd) ? ramRdata : c0Reg;
  assign c1Now = (capPending &&  capOdd) ? ramRdata : c1Reg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regionSel  <= 1'b0;
      relIdx     <= '0;
      capPending <= 1'b0;
      capOdd     <= 1'b0;
      c0Reg      <= '0;
      c1Reg      <= '0;
      outData    <= '0;
    end else begin
      if (strobe.latchPoly) begin
        regionSel <= isSecret;
        relIdx    <= relFull[REL_W-1:0];
      end
      capPending <= strobe.issueRd;
      capOdd     <= strobe.rdOdd;
      if (capPending && !capOdd) c0Reg <= ramRdata;
      if (capPending &&  capOdd) c1Reg <= ramRdata;
      if (strobe.loadByte) begin
        unique case (strobe.byteSel)
          BYTE_LO:  outData <= c0Now[7:0];
          BYTE_MID: outData <= {c1Now[3:0], c0Now[11:8]};
          BYTE_HI:  outData <= c1Now[11:4];
          default:  outData <= c0Now[7:0];
        endcase
      end
    end
  end

  // the two reads of a pair alternate even then odd index
  p_pair_order_r1: assert property (@(posedge clk) disable iff (!rstN)
    (capPending && !capOdd && ramRen) |-> ramAddr[0]);

  // region stays fixed while reads are in flight
  p_region_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (capPending && ramRen) |-> $stable(ramSel) && $stable(relIdx));

  // the index width must hold the counter plus parity bit
  initial begin
    a_idx_width: assert (IDX_W >= 2);
  end

endmodule

// File: rtl/coef_pair_packer.sv
module coef_pair_packer
  import coef_pair_packer_pkg::*;
#(
  parameter int POLY_W  = 5,
  parameter int REL_W   = 4,
  parameter int N_COEFF = 256
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              start,
  input  logic [POLY_W-1:0]                 polyIdx,
  input  logic [POLY_W-1:0]                 kPolys,
  output logic                              ramRen,
  output logic                              ramSel,
  output logic [REL_W+$clog2(N_COEFF)-1:0]  ramAddr,
  input  logic [11:0]                       ramRdata,
  output logic [7:0]                        outData,
  output logic                              outValid,
  input  logic                              outReady,
  output logic                              outLast,
  output logic                              done
);

  localparam int PAIR_W = $clog2(N_COEFF) - 1;

  packStrobe_t       strobe;
  logic [PAIR_W-1:0] rdPair;

  coef_pair_packer_ctrl #(.PAIR_W(PAIR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .outReady (outReady),
    .strobe   (strobe),
    .rdPair   (rdPair),
    .outValid (outValid),
    .outLast  (outLast),
    .done     (done)
  );

  coef_pair_packer_dp #(
    .POLY_W (POLY_W),
    .REL_W  (REL_W),
    .COEF_W (12),
    .N_COEFF(N_COEFF)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdPair   (rdPair),
    .polyIdx  (polyIdx),
    .kPolys   (kPolys),
    .ramRen   (ramRen),
    .ramSel   (ramSel),
    .ramAddr  (ramAddr),
    .ramRdata (ramRdata),
    .outData  (outData)
  );

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> (done && !outValid));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: tb/coef_pair_packer_tb.sv
module coef_pair_packer_tb;

  localparam int POLY_W = 5;
  localparam int REL_W  = 4;
  localparam int AW     = REL_W + 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [POLY_W-1:0] polyIdx = '0;
  logic [POLY_W-1:0] kPolys = '0;
  logic ramRen, ramSel;
  logic [AW-1:0] ramAddr;
  logic [11:0] ramRdata = '0;
  logic [7:0] outData;
  logic outValid, outLast, done;
  logic outReady = 1'b0;

  int errors = 0;
  int checks = 0;
  int renCount = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  coef_pair_packer #(.POLY_W(POLY_W), .REL_W(REL_W), .N_COEFF(256)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .polyIdx(polyIdx), .kPolys(kPolys),
    .ramRen(ramRen), .ramSel(ramSel), .ramAddr(ramAddr), .ramRdata(ramRdata),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .outLast(outLast), .done(done)
  );

  function automatic logic [11:0] coefVal(input int sel, input int rel, input int idx);
    return 12'((sel * 1237 + rel * 389 + idx * 53 + (idx * idx) % 97 + 7) & 12'hFFF);
  endfunction

  // registered-read RAM model
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (ramRen) begin
      ramRdata <= coefVal(int'(ramSel), int'(ramAddr[AW-1:8]), int'(ramAddr[7:0]));
      renCount <= renCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expByte(input int sel, input int rel, input int n);
    int p = n / 3;
    logic [11:0] c0 = coefVal(sel, rel, 2 * p);
    logic [11:0] c1 = coefVal(sel, rel, 2 * p + 1);
    case (n % 3)
      0: return int'(c0[7:0]);
      1: return int'({c1[3:0], c0[11:8]});
      default: return int'(c1[11:4]);
    endcase
  endfunction

  // mode 0: ready always high; 1: pseudo-random ready; poke: stray start mid-run
  task automatic runPoly(input int poly, input int k, input int mode, input bit poke);
    int sel = (poly >= k) ? 1 : 0;
    int rel = (poly >= k) ? poly - k : poly;
    int n = 0;
    int firstCyc = 0;
    int lastCyc = 0;
    int guard = 0;
    logic [7:0] lfsr = 8'hA5;
    bit stalled = 0;
    logic [7:0] heldData = '0;
    @(negedge clk);
    renCount = 0;
    polyIdx = POLY_W'(poly);
    kPolys = POLY_W'(k);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    polyIdx = POLY_W'(poly ^ 3);
    while (n < 384 && guard < 5000) begin
      guard++;
      if (stalled) begin
        check(outValid === 1'b1 && outData === heldData, "R7 hold", int'(outData), int'(heldData));
      end
      if (poke && n == 100) start = 1'b1; else start = 1'b0;
      outReady = (mode == 0) ? 1'b1 : lfsr[0] | lfsr[3];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      #1;
      stalled = outValid && !outReady;
      heldData = outData;
      if (outValid && outReady) begin
        case (n % 3)
          0: check(outData === 8'(expByte(sel, rel, n)), "R2/R5 byte0", int'(outData), expByte(sel, rel, n));
          1: check(outData === 8'(expByte(sel, rel, n)), "R3 byte1", int'(outData), expByte(sel, rel, n));
          default: check(outData === 8'(expByte(sel, rel, n)), "R4 byte2", int'(outData), expByte(sel, rel, n));
        endcase
        if (n == 383 || outLast) check(outLast === (n == 383), "R6 last flag", n, 383);
        if (n == 0) firstCyc = cycles;
        lastCyc = cycles;
        n++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    outReady = 1'b0;
    check(n == 384, "R6 byte count", n, 384);
    check(done === 1'b1 && outValid === 1'b0, "R8 done after last", int'(done), 1);
    if (mode == 0) check(lastCyc - firstCyc == 383, "R10 throughput", lastCyc - firstCyc, 383);
    @(negedge clk);
    check(done === 1'b0, "R8 done one cycle", int'(done), 0);
    check(renCount == 256, "R1 read count", renCount, 256);
    check(outValid === 1'b0, "R9 no extra run", int'(outValid), 0);
  endtask

  task automatic testReset();
    check(outValid === 1'b0, "R11 valid", int'(outValid), 0);
    check(done === 1'b0, "R11 done", int'(done), 0);
    check(ramRen === 1'b0, "R11 ren", int'(ramRen), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runPoly(0, 3, 0, 0);   // R5 result region, first
    runPoly(2, 3, 0, 0);   // R5 result region, last
    runPoly(3, 3, 0, 0);   // R5 secret region, relative 0
    runPoly(5, 3, 1, 0);   // R7 backpressure, secret region
    runPoly(1, 4, 1, 1);   // R9 stray start during run
    runPoly(9, 2, 0, 1);   // R5 secret region, relative 7
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule